// File: doc/BRIEF.md
# Modem Line Change Detector

This block watches four incoming modem handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line is brought into the local clock domain through a short chain of flip-flops. The block then shows the settled level of every line and keeps a sticky flag for each one that records that the line has moved. Software reads one nine-bit status word. Writing a one to a flag position clears that flag.

Carrier detect, clear-to-send and data-set-ready raise their flag on a rise or a fall. The ring indicator raises its flag only when it falls from asserted to deasserted, which marks the end of a ring burst. A level output that is high while any flag is set, and a one-cycle pulse when a flag newly sets, drive the interrupt controller. One further bit of the same word is a plain read/write flow-control mode bit.

Line index (input bit) assignment: 0 = clear-to-send, 1 = data-set-ready, 2 = ring indicator, 3 = carrier detect. Status word layout: bits 3:0 hold the change flags of lines 0..3, bits 7:4 hold the synchronized levels of lines 0..3, and bit 8 holds the flow-control mode bit.

Top module: `modem_delta_det`

## Requirements
- R1: After reset, `rd_data` reads 0 and both `chg_pending` and `chg_pulse` are low.
- R2: A level change on input bit i appears in `rd_data[4+i]` after SYNC_STAGES (default 2) rising clock edges.
- R3: For lines 0, 1 and 3, a rise or a fall of the synchronized level sets flag `rd_data[i]` one clock edge after the new level appears in `rd_data[4+i]`.
- R4: For line 2 (ring), only a 1-to-0 change of the synchronized level sets `rd_data[2]`; a 0-to-1 change leaves it unchanged.
- R5: A cycle with `wr_en` high and `wr_data[i]` = 1 (i in 0..3) clears flag i at the next edge; a zero in that position leaves the flag as it was.
- R6: When a line's flag-setting change and a clearing write for the same flag fall in the same cycle, the flag is set afterwards.
- R7: A cycle with `wr_en` high loads `wr_data[8]` into the flow-control mode bit `rd_data[8]`; it keeps that value while `wr_en` is low.
- R8: `chg_pending` is high exactly when at least one of `rd_data[3:0]` is 1.
- R9: `chg_pulse` is high for one cycle, the same cycle a flag first reads 1 after reading 0; a change on a line whose flag is already set gives no pulse.
- R10: Written values in `wr_data[7:4]` have no effect; the level bits keep following the lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_raw | input | 4 | Asynchronous modem lines, 1 = asserted (0 CTS, 1 DSR, 2 RI, 3 DCD) |
| wr_en | input | 1 | Status-word write strobe |
| wr_data | input | 9 | Write data: bits 3:0 write-one-to-clear, bit 8 mode |
| rd_data | output | 9 | Status word: flags, levels, mode bit |
| chg_pending | output | 1 | High while any change flag is set |
| chg_pulse | output | 1 | One-cycle pulse when a flag newly sets |

## Verification
A wrong synchronizer depth or a corrupted previous-level register shows in the level bits or in a flag that sets one edge early or late. The bench catches it on the first line change because it compares every cycle. If the ring line is given the wrong edge kind, the flag sets on a rise or misses a fall within three edges of that transition. A clear-versus-set priority error or a stuck flow bit shows on the read word at the edge after the offending write. A missing or doubled pulse shows in the same cycle as the flag change.

// File: rtl/mdd_pkg.sv
package mdd_pkg;
   localparam int MDD_LINES   = 4;
   localparam int FLG_LSB     = 0;
   localparam int LVL_LSB     = FLG_LSB + MDD_LINES;
   localparam int MODE_BIT    = LVL_LSB + MDD_LINES;
   localparam int STAT_W      = MODE_BIT + 1;

   typedef enum int {
      LN_CTS = 0,
      LN_DSR = 1,
      LN_RI  = 2,
      LN_DCD = 3
   } line_idx_e;
endpackage

// File: rtl/mdd_sync.sv
module mdd_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_depth
      $error("mdd_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mdd_flag.sv
module mdd_flag #(
   parameter bit TRAIL_ONLY = 1'b0,
   parameter bit IDLE_VAL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic clr,
   output logic flag,
   output logic newly_set
);
   logic prev_q;
   logic hit;
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= lvl;
   end

   if (TRAIL_ONLY) begin : g_trail
      assign hit = prev_q & ~lvl;
   end else begin : g_any
      assign hit = prev_q ^ lvl;
   end

   // a detected change outranks a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= hit | (flag_q & ~clr);
   end

   assign flag      = flag_q;
   assign newly_set = hit & ~flag_q;
endmodule

// File: rtl/modem_delta_det.sv
module modem_delta_det
   import mdd_pkg::*;
#(
   parameter int             SYNC_STAGES = 2,
   parameter logic [3:0]     TRAIL_MASK  = 4'b0100,
   parameter logic [3:0]     IDLE_LEVEL  = 4'b0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       line_raw,
   input  logic             wr_en,
   input  logic [8:0]       wr_data,
   output logic [8:0]       rd_data,
   output logic             chg_pending,
   output logic             chg_pulse
);
   localparam int NL = MDD_LINES;

   if (STAT_W != 9) begin : g_bad_width
      $error("modem_delta_det: status word layout must be 9 bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modem_delta_det: SYNC_STAGES must be at least 2");
   end

   logic [NL-1:0] lvl;
   logic [NL-1:0] flags;
   logic [NL-1:0] newly;
   logic [NL-1:0] clr;
   logic          mode_q;
   logic          pulse_q;

   assign clr = {NL{wr_en}} & wr_data[FLG_LSB +: NL];

   for (genvar i = 0; i < NL; i++) begin : g_line
      mdd_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (IDLE_LEVEL[i])
      ) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .d_async (line_raw[i]),
         .q_sync  (lvl[i])
      );

      mdd_flag #(
         .TRAIL_ONLY (TRAIL_MASK[i]),
         .IDLE_VAL   (IDLE_LEVEL[i])
      ) u_flag (
         .clk       (clk),
         .rst_n     (rst_n),
         .lvl       (lvl[i]),
         .clr       (clr[i]),
         .flag      (flags[i]),
         .newly_set (newly[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= 1'b0;
      else if (wr_en) mode_q <= wr_data[MODE_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= |newly;
   end

   assign rd_data     = {mode_q, lvl, flags};
   assign chg_pending = |flags;
   assign chg_pulse   = pulse_q;
endmodule

// File: rtl/mdd_checker.sv
module mdd_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [8:0] wr_data,
   input logic [8:0] rd_data,
   input logic       chg_pending,
   input logic       chg_pulse
);
   // R3: carrier detect level change raises its flag at the next edge
   a_r3_dcd_any_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7] != $past(rd_data[7])) |=> rd_data[3]);

   // R4: ring rise alone never raises the ring flag
   a_r4_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[2] && $rose(rd_data[6])) |=> !rd_data[2]);

   // R5: clearing write with no concurrent change clears the CTS flag
   a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && (rd_data[4] == $past(rd_data[4]))) |=> !rd_data[0]);

   // R6: change wins over a concurrent clear
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && (rd_data[4] != $past(rd_data[4]))) |=> rd_data[0]);

   // R7: mode bit loads on write
   a_r7_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[8] == $past(wr_data[8])));

   // R9: a pulse only accompanies a flag that was clear one cycle earlier
   a_r9_pulse_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse |-> ((rd_data[3:0] & ~$past(rd_data[3:0])) != 4'b0));

   // R8: pending level tracks the flags after any pulse
   a_r8_pulse_implies_pending: assert property (@(posedge clk) disable iff (!rst_n)
      chg_pulse |-> chg_pending);
endmodule

bind modem_delta_det mdd_checker u_mdd_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .chg_pending (chg_pending),
   .chg_pulse   (chg_pulse)
);

// File: tb/modem_delta_det_bench.sv
`timescale 1ns/1ps
module modem_delta_det_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] line_raw = 4'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = 9'b0;
   logic [8:0] rd_data;
   logic       chg_pending;
   logic       chg_pulse;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   modem_delta_det u_modem_delta_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_raw    (line_raw),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .chg_pending (chg_pending),
      .chg_pulse   (chg_pulse)
   );

   // reference model built from the requirements
   logic [3:0] m_s1, m_lvl, m_prev, m_flag;
   logic       m_mode, m_pulse;

   function automatic logic [3:0] set_vec(logic [3:0] cur, logic [3:0] prv);
      logic [3:0] r;
      for (int i = 0; i < 4; i++)
         r[i] = (i == 2) ? (prv[i] & ~cur[i]) : (prv[i] ^ cur[i]);
      return r;
   endfunction

   function automatic logic [8:0] exp_word();
      return {m_mode, m_lvl, m_flag};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_lvl <= '0; m_prev <= '0; m_flag <= '0;
         m_mode <= 1'b0; m_pulse <= 1'b0;
      end else begin
         m_s1   <= line_raw;
         m_lvl  <= m_s1;
         m_prev <= m_lvl;
         m_flag <= set_vec(m_lvl, m_prev) | (m_flag & ~({4{wr_en}} & wr_data[3:0]));
         m_pulse <= |(set_vec(m_lvl, m_prev) & ~m_flag);
         if (wr_en) m_mode <= wr_data[8];
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [8:0] v);
      wr_en = 1'b1; wr_data = v;
      tick(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 rd_data", rd_data, 0);
      chk("R1 pending", chg_pending, 0);
      chk("R1 pulse", chg_pulse, 0);

      // R2 / R3 / R8 / R9: CTS rises
      line_raw[0] = 1'b1;
      tick(2);
      chk("R2 cts level", rd_data[4], 1);
      chk("R3 cts flag not yet", rd_data[0], 0);
      tick(1);
      chk("R3 cts flag", rd_data[0], 1);
      chk("R9 pulse", chg_pulse, 1);
      chk("R8 pending", chg_pending, 1);
      tick(1);
      chk("R9 pulse single", chg_pulse, 0);

      // R9: further change while flag set gives no pulse
      line_raw[0] = 1'b0;
      tick(3);
      chk("R9 no pulse when set", chg_pulse, 0);
      chk("R3 cts fall keeps flag", rd_data[0], 1);

      // R5: write zero keeps, write one clears
      wr(9'h000);
      chk("R5 zero write keeps", rd_data[0], 1);
      wr(9'h001);
      chk("R5 clear", rd_data[0], 0);
      chk("R8 pending low", chg_pending, 0);

      // R4: ring rise then fall
      line_raw[2] = 1'b1;
      tick(4);
      chk("R4 ri level", rd_data[6], 1);
      chk("R4 ri rise no flag", rd_data[2], 0);
      line_raw[2] = 1'b0;
      tick(3);
      chk("R4 ri fall flag", rd_data[2], 1);
      wr(9'h004);

      // R6: DSR change coincides with clear write
      line_raw[1] = 1'b1;
      tick(2);
      wr_en = 1'b1; wr_data = 9'h002;
      tick(1);
      wr_en = 1'b0; wr_data = '0;
      chk("R6 set wins", rd_data[1], 1);
      wr(9'h002);

      // R3: carrier detect both edges
      line_raw[3] = 1'b1;
      tick(3);
      chk("R3 dcd rise", rd_data[3], 1);
      wr(9'h008);
      line_raw[3] = 1'b0;
      tick(3);
      chk("R3 dcd fall", rd_data[3], 1);
      wr(9'h008);

      // R7: mode bit
      wr(9'h100);
      chk("R7 mode set", rd_data[8], 1);
      tick(2);
      chk("R7 mode hold", rd_data[8], 1);
      wr(9'h000);
      chk("R7 mode clear", rd_data[8], 0);

      // R10: level bits not writable
      wr(9'h0F0);
      chk("R10 levels unchanged", rd_data[7:4], 4'b0010);

      // random phase against the model
      void'($urandom(32'h5EED_1234));
      for (int c = 0; c < 3000; c++) begin
         if ($urandom_range(7, 0) == 0) line_raw[$urandom_range(3, 0)] ^= 1'b1;
         if ($urandom_range(5, 0) == 0) begin
            wr_en = 1'b1; wr_data = 9'($urandom);
         end else begin
            wr_en = 1'b0; wr_data = '0;
         end
         tick(1);
         chk("R2/R3/R4/R5/R7 word", rd_data, exp_word());
         chk("R8 pending", chg_pending, |m_flag);
         chk("R9 pulse", chg_pulse, m_pulse);
      end
      wr_en = 1'b0;
      finish_run();
   end
endmodule